// File: doc/BRIEF.md
# CPU Power-Mode and Debug-Halt Sequencer

This block decides, every clock, whether a small CPU core is executing, parked in a low-power wait, fully stopped, or held in a debug-halted state. It also produces the clock enables that each of these states implies. Its inputs are:

- decoded instruction strobes for wait, stop and software breakpoint;
- an instruction-complete strobe;
- interrupt and core-reset requests;
- a periodic wake tick;
- two configuration bits;
- decoded debug commands: enter-halt, resume, tagged resume and single-step.

Wait clears the interrupt mask and gates only the CPU clock. Stop gates every clock, with two exceptions, and both are sampled on stop entry. If the debug-enable bit is set, the oscillator stays on and a halt command can pull the core out of stop. If the keep-alive option is set, a minimal clock stays on so that the periodic tick can wake the core.

The debug-halted state can be left only by a core reset, by a resume command, or by single-step. Single-step releases the core for one instruction and then returns it to the halted state. All outputs are registered. An event sampled on a rising edge is reflected in the outputs right after that same edge.

Top module: `pm_dbg_seq`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are cpu_clk_en=1, sys_clk_en=1, osc_en=1, halted=0, imask_clr=0, step_go=0.
- R2: In the running state, `op_wait` produces a one-cycle `imask_clr` pulse. In the same cycle `cpu_clk_en` drops to 0, while `sys_clk_en` and `osc_en` stay 1.
- R3: In wait, `irq_req` (or `core_rst`) brings the core back to running, with all three clock enables at 1.
- R4: In wait, `cmd_halt` enters the debug-halted state: `halted`=1 with all clock enables at 1. When `cmd_halt` and `irq_req` arrive in the same cycle, halt wins.
- R5: In the running state, `op_stop` with `dbg_en`=0 and `keep_alive`=0 clears `cpu_clk_en`, `sys_clk_en` and `osc_en`.
- R6: If `keep_alive` was 1 at stop entry, `osc_en` stays 1 during stop and `wake_tick` returns the core to running. If it was 0, `wake_tick` is ignored.
- R7: If `dbg_en` was 1 at stop entry, `osc_en` stays 1 throughout stop, even if `dbg_en` later falls. `cmd_halt` then enters the debug-halted state.
- R8: If `dbg_en` was 0 at stop entry, `cmd_halt` is ignored in stop. The core stays stopped until `irq_req`, `core_rst`, or an enabled `wake_tick`.
- R9: In the running state, `op_bkpt` enters the debug-halted state. Once halted, interrupt, wait, stop, breakpoint, tick and instruction-complete inputs have no effect.
- R10: The debug-halted state is left for running by `cmd_go` or `cmd_tgo`, which clears `halted`.
- R11: In the debug-halted state, `cmd_step` gives a one-cycle `step_go` pulse and clears `halted`. The next `insn_done` sets `halted` again. Until then, debug commands are ignored.
- R12: `core_rst` has priority over every other input in every state. In the cycle after it is sampled, the outputs are those of R1.
- R13: In the running state, inputs are ranked from highest to lowest as `cmd_halt`, `op_bkpt`, `op_stop`, `op_wait`. Interrupt, tick, instruction-complete, resume and step inputs have no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| op_wait | input | 1 | Wait instruction strobe |
| op_stop | input | 1 | Stop instruction strobe |
| op_bkpt | input | 1 | Software breakpoint instruction strobe |
| insn_done | input | 1 | Instruction-complete strobe |
| irq_req | input | 1 | Pending interrupt request |
| core_rst | input | 1 | Core reset request |
| wake_tick | input | 1 | Periodic internal wake tick |
| dbg_en | input | 1 | Debug-enable control bit |
| keep_alive | input | 1 | Keep a minimal clock running during stop |
| cmd_halt | input | 1 | Debug command: enter halted state |
| cmd_go | input | 1 | Debug command: resume |
| cmd_step | input | 1 | Debug command: execute one instruction |
| cmd_tgo | input | 1 | Debug command: tagged resume |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock enable |
| osc_en | output | 1 | Oscillator enable |
| imask_clr | output | 1 | Interrupt-mask clear strobe |
| halted | output | 1 | Debug-halted flag |
| step_go | output | 1 | Single-step release pulse |

## Verification
The interesting collisions are between a wake source and a debug command in the same cycle. Examples are `irq_req` together with `cmd_halt` while in wait, and `core_rst` together with a resume or step command while halted. The bench enters each of seven start conditions: running, wait, the three stop configurations, halted, and stepping. From each one it applies every combination of the eleven event inputs in a single cycle, so all such pairs occur. An arithmetic model of the priority rules in R4, R12 and R13 predicts all six registered outputs after that edge, and the bench compares them.

// File: rtl/pm_dbg_pkg.sv
package pm_dbg_pkg;
  typedef enum logic [2:0] {
    PM_RUN  = 3'd0,
    PM_WAIT = 3'd1,
    PM_STOP = 3'd2,
    PM_HALT = 3'd3,
    PM_STEP = 3'd4
  } pm_state_t;
endpackage

// File: rtl/pm_stop_cfg.sv
module pm_stop_cfg (
  input  logic clk,
  input  logic rst,
  input  logic enter_stop,
  input  logic dbg_en,
  input  logic keep_alive,
  output logic halt_ok,
  output logic tick_ok,
  output logic osc_hold_nxt
);
  logic lat_dbg, lat_keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_dbg  <= 1'b0;
      lat_keep <= 1'b0;
    end else if (enter_stop) begin
      lat_dbg  <= dbg_en;
      lat_keep <= keep_alive;
    end
  end

  assign halt_ok      = lat_dbg;
  assign tick_ok      = lat_keep;
  assign osc_hold_nxt = enter_stop ? (dbg_en | keep_alive) : (lat_dbg | lat_keep);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enter_stop |=> (lat_dbg == $past(lat_dbg)) && (lat_keep == $past(lat_keep)));
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_dbg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      op_wait,
  input  logic      op_stop,
  input  logic      op_bkpt,
  input  logic      insn_done,
  input  logic      irq_req,
  input  logic      core_rst,
  input  logic      wake_tick,
  input  logic      cmd_halt,
  input  logic      cmd_go,
  input  logic      cmd_step,
  input  logic      cmd_tgo,
  input  logic      halt_ok,
  input  logic      tick_ok,
  output pm_state_t st_nxt,
  output logic      enter_stop,
  output logic      enter_wait,
  output logic      enter_step
);
  pm_state_t st;

  always_comb begin
    st_nxt = st;
    if (core_rst) begin
      st_nxt = PM_RUN;
    end else begin
      unique case (st)
        PM_RUN: begin
          if (cmd_halt || op_bkpt) st_nxt = PM_HALT;
          else if (op_stop)        st_nxt = PM_STOP;
          else if (op_wait)        st_nxt = PM_WAIT;
        end
        PM_WAIT: begin
          if (cmd_halt)     st_nxt = PM_HALT;
          else if (irq_req) st_nxt = PM_RUN;
        end
        PM_STOP: begin
          if (cmd_halt && halt_ok)                  st_nxt = PM_HALT;
          else if (irq_req || (wake_tick && tick_ok)) st_nxt = PM_RUN;
        end
        PM_HALT: begin
          if (cmd_go || cmd_tgo) st_nxt = PM_RUN;
          else if (cmd_step)     st_nxt = PM_STEP;
        end
        PM_STEP: begin
          if (insn_done) st_nxt = PM_HALT;
        end
        default: st_nxt = PM_RUN;
      endcase
    end
  end

  assign enter_stop = (st == PM_RUN)  && (st_nxt == PM_STOP);
  assign enter_wait = (st == PM_RUN)  && (st_nxt == PM_WAIT);
  assign enter_step = (st == PM_HALT) && (st_nxt == PM_STEP);

  always_ff @(posedge clk) begin
    if (rst) st <= PM_RUN;
    else     st <= st_nxt;
  end

  // R12
  rst_prio_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> st == PM_RUN);
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PM_HALT) && !core_rst && !cmd_go && !cmd_tgo && !cmd_step |=> st == PM_HALT);
  // R11
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PM_STEP) && !core_rst && !insn_done |=> st == PM_STEP);
  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PM_STOP) && !halt_ok && !core_rst && !irq_req && !(wake_tick && tick_ok)
      |=> st == PM_STOP);
endmodule

// File: rtl/pm_outreg.sv
module pm_outreg
  import pm_dbg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_state_t st_nxt,
  input  logic      enter_wait,
  input  logic      enter_step,
  input  logic      osc_hold_nxt,
  output logic      cpu_clk_en,
  output logic      sys_clk_en,
  output logic      osc_en,
  output logic      imask_clr,
  output logic      halted,
  output logic      step_go
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      sys_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      imask_clr  <= 1'b0;
      halted     <= 1'b0;
      step_go    <= 1'b0;
    end else begin
      cpu_clk_en <= (st_nxt != PM_WAIT) && (st_nxt != PM_STOP);
      sys_clk_en <= (st_nxt != PM_STOP);
      osc_en     <= (st_nxt != PM_STOP) || osc_hold_nxt;
      imask_clr  <= enter_wait;
      halted     <= (st_nxt == PM_HALT);
      step_go    <= enter_step;
    end
  end

  // R5
  stop_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !sys_clk_en |-> !cpu_clk_en);
  // R4
  halt_clk_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> cpu_clk_en && sys_clk_en && osc_en);
  // R2
  imask_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    imask_clr |-> !cpu_clk_en && sys_clk_en);
  // R11
  step_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halted, step_go, imask_clr}));
endmodule

// File: rtl/pm_dbg_seq.sv
module pm_dbg_seq
  import pm_dbg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_wait,
  input  logic op_stop,
  input  logic op_bkpt,
  input  logic insn_done,
  input  logic irq_req,
  input  logic core_rst,
  input  logic wake_tick,
  input  logic dbg_en,
  input  logic keep_alive,
  input  logic cmd_halt,
  input  logic cmd_go,
  input  logic cmd_step,
  input  logic cmd_tgo,
  output logic cpu_clk_en,
  output logic sys_clk_en,
  output logic osc_en,
  output logic imask_clr,
  output logic halted,
  output logic step_go
);
  pm_state_t st_nxt;
  logic enter_stop, enter_wait, enter_step;
  logic halt_ok, tick_ok, osc_hold_nxt;

  pm_seq u_seq (
    .clk(clk), .rst(rst),
    .op_wait(op_wait), .op_stop(op_stop), .op_bkpt(op_bkpt),
    .insn_done(insn_done), .irq_req(irq_req), .core_rst(core_rst),
    .wake_tick(wake_tick), .cmd_halt(cmd_halt), .cmd_go(cmd_go),
    .cmd_step(cmd_step), .cmd_tgo(cmd_tgo),
    .halt_ok(halt_ok), .tick_ok(tick_ok),
    .st_nxt(st_nxt), .enter_stop(enter_stop),
    .enter_wait(enter_wait), .enter_step(enter_step)
  );

  pm_stop_cfg u_cfg (
    .clk(clk), .rst(rst), .enter_stop(enter_stop),
    .dbg_en(dbg_en), .keep_alive(keep_alive),
    .halt_ok(halt_ok), .tick_ok(tick_ok), .osc_hold_nxt(osc_hold_nxt)
  );

  pm_outreg u_out (
    .clk(clk), .rst(rst), .st_nxt(st_nxt),
    .enter_wait(enter_wait), .enter_step(enter_step),
    .osc_hold_nxt(osc_hold_nxt),
    .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .osc_en(osc_en),
    .imask_clr(imask_clr), .halted(halted), .step_go(step_go)
  );
endmodule

// File: tb/pm_dbg_seq_test.sv
`timescale 1ns/1ps
module pm_dbg_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic op_wait = 0, op_stop = 0, op_bkpt = 0, insn_done = 0, irq_req = 0;
  logic core_rst = 0, wake_tick = 0, dbg_en = 0, keep_alive = 0;
  logic cmd_halt = 0, cmd_go = 0, cmd_step = 0, cmd_tgo = 0;
  logic cpu_clk_en, sys_clk_en, osc_en, imask_clr, halted, step_go;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_dbg_seq uut (
    .clk(clk), .rst(rst), .op_wait(op_wait), .op_stop(op_stop), .op_bkpt(op_bkpt),
    .insn_done(insn_done), .irq_req(irq_req), .core_rst(core_rst),
    .wake_tick(wake_tick), .dbg_en(dbg_en), .keep_alive(keep_alive),
    .cmd_halt(cmd_halt), .cmd_go(cmd_go), .cmd_step(cmd_step), .cmd_tgo(cmd_tgo),
    .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .osc_en(osc_en),
    .imask_clr(imask_clr), .halted(halted), .step_go(step_go)
  );

  // event bit order: 0 wait,1 stop,2 bkpt,3 done,4 irq,5 core_rst,6 tick,
  // 7 halt cmd,8 go,9 step,10 tagged go
  task automatic apply(input logic [10:0] e);
    @(negedge clk);
    op_wait = e[0]; op_stop = e[1]; op_bkpt = e[2]; insn_done = e[3];
    irq_req = e[4]; core_rst = e[5]; wake_tick = e[6]; cmd_halt = e[7];
    cmd_go = e[8]; cmd_step = e[9]; cmd_tgo = e[10];
    @(posedge clk);
    #1;
    {op_wait, op_stop, op_bkpt, insn_done, irq_req, core_rst, wake_tick,
     cmd_halt, cmd_go, cmd_step, cmd_tgo} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  function automatic logic [5:0] outs();
    return {cpu_clk_en, sys_clk_en, osc_en, halted, imask_clr, step_go};
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    total++;
    if (outs() !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b", req, outs(), exp);
    end
  endtask

  // start conditions: 0 run,1 wait,2 stop plain,3 stop dbg,4 stop keep,5 halted,6 stepping
  task automatic setup(input int s);
    do_reset();
    dbg_en = (s == 3);
    keep_alive = (s == 4);
    case (s)
      1: apply(11'b1);
      2, 3, 4: apply(11'b10);
      5: apply(11'b100);
      6: begin apply(11'b100); apply(11'b010_0000_0000); end
      default: ;
    endcase
    dbg_en = 1'b0;
  endtask

  function automatic logic [5:0] model(input int s, input logic [10:0] e);
    int m, n;
    logic ld, lk, oh;
    m = (s == 0) ? 0 : (s == 1) ? 1 : (s <= 4) ? 2 : (s == 5) ? 3 : 4;
    ld = (s == 3);
    lk = (s == 4);
    oh = ld | lk;
    n = m;
    if (e[5]) n = 0;
    else case (m)
      0: if (e[7] || e[2]) n = 3;
         else if (e[1]) begin n = 2; oh = 1'b0; end
         else if (e[0]) n = 1;
      1: if (e[7]) n = 3; else if (e[4]) n = 0;
      2: if (e[7] && ld) n = 3; else if (e[4] || (e[6] && lk)) n = 0;
      3: if (e[8] || e[10]) n = 0; else if (e[9]) n = 4;
      default: if (e[3]) n = 3;
    endcase
    return {!(n == 1 || n == 2), n != 2, (n != 2) || oh, n == 3,
            (m == 0) && (n == 1), (m == 3) && (n == 4)};
  endfunction

  function automatic string tag(input int s, input logic [10:0] e);
    if (e[5]) return "R12";
    case (s)
      0: return "R13";
      1: return "R4";
      2: return "R8";
      3: return "R7";
      4: return "R6";
      5: return "R10";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG_CYCLES && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", 6'b111000);
    // R2 wait entry pulse, then pulse gone
    apply(11'b1);          check("R2", 6'b011010);
    apply(11'b0);          check("R2", 6'b011000);
    // R3 interrupt wakes from wait
    apply(11'b1_0000);     check("R3", 6'b111000);
    // R5 plain stop gates everything
    apply(11'b10);         check("R5", 6'b000000);
    apply(11'b1000_0000);  check("R8", 6'b000000);
    apply(11'b1_0000);     check("R3", 6'b111000);
    // R9 breakpoint, halted ignores irq/wait/stop
    apply(11'b100);        check("R9", 6'b111100);
    apply(11'b1_0011);     check("R9", 6'b111100);
    // R11 single step
    apply(11'b010_0000_0000); check("R11", 6'b111001);
    apply(11'b0);             check("R11", 6'b111000);
    apply(11'b1_0000_0000);   check("R11", 6'b111000);
    apply(11'b1000);          check("R11", 6'b111100);
    // R10 go
    apply(11'b1_0000_0000);   check("R10", 6'b111000);

    // exhaustive single-cycle event sweep from every start condition
    for (int s = 0; s < 7; s++) begin
      for (int v = 0; v < 2048; v++) begin
        setup(s);
        apply(v[10:0]);
        check(tag(s, v[10:0]), model(s, v[10:0]));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule